// File: doc/BRIEF.md
# Order-Wire Overhead Byte Capture

This block receives the serial order-wire overhead stream of an STS-12 receive path and turns it into a parallel word. A bit line, a valid qualifier and a one-clock frame marker arrive from a source that changes them on the falling edge of the overhead clock. The block samples all three on the rising edge. A burst opens on the edge where valid and the frame marker are both high. That edge delivers the first bit. The burst closes on the first edge where valid is low.

Each burst is expected to carry the E1, F1 and E2 bytes of one frame, in that sequence, most significant bit first. When a burst closes after exactly the expected number of bits, the three bytes go to a held output word and a one-cycle ready strobe is raised. A burst of any other length is discarded and sets a sticky length-error flag. A frame marker that arrives inside a burst also sets that flag, and collection restarts from that marker's bit.

Top module: `orderwire_capture`

## Requirements
- R1: After reset, `ow_word` is all zeros and both `ow_ready` and `ow_len_err` are low.
- R2: A burst begins only on a rising edge where `ow_vld` and `ow_fp` are both high, and the bit sampled on that edge is the first bit of the burst.
- R3: While no burst is open, `ow_vld` high with `ow_fp` low is ignored: no burst begins, `ow_ready` stays low and `ow_word` and `ow_len_err` keep their values.
- R4: Bits are shifted in most significant first. The first bit of a complete burst appears at `ow_word[23]`. E1 occupies bits 23:16, F1 occupies bits 15:8 and E2 occupies bits 7:0.
- R5: When a burst closes after exactly 24 bits, `ow_word` takes the captured bytes and `ow_ready` goes high in the cycle after the edge that sampled `ow_vld` low.
- R6: A burst that closes with fewer than 24 bits leaves `ow_word` unchanged, raises no `ow_ready` and sets `ow_len_err`.
- R7: A burst that closes with more than 24 bits leaves `ow_word` unchanged, raises no `ow_ready` and sets `ow_len_err`.
- R8: A frame marker sampled with `ow_vld` high inside an open burst sets `ow_len_err` and restarts collection from that bit. A restarted burst of exactly 24 bits is then delivered normally.
- R9: Once set, `ow_len_err` stays high until reset.
- R10: `ow_ready` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overhead clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ow_bit | input | 1 | Serial order-wire data bit |
| ow_vld | input | 1 | High while `ow_bit` carries an order-wire bit |
| ow_fp | input | 1 | One-clock marker aligned with the first E1 bit |
| ow_word | output | 24 | Last complete capture: E1 in 23:16, F1 in 15:8, E2 in 7:0 |
| ow_ready | output | 1 | One-cycle strobe when `ow_word` has just been updated |
| ow_len_err | output | 1 | Sticky flag for a bad burst length or a marker inside a burst |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three bytes per frame and a 24-bit word. At this size, every burst length from 1 to 30 can be run from a fresh reset. These lengths cover each short and each long case on both sides of the complete length. The bench also drives a walking one through all 24 bit positions. This confirms the placement of every bit in the word, including the edge bytes E1 and E2. Restarts caused by a frame marker are tried at several depths inside a burst.

// File: rtl/orderwire_pkg.sv
package orderwire_pkg;

  // bit counter type; sized for word lengths below 255 bits
  typedef logic [7:0] ow_cnt_t;

  // advance the bit count, holding at cap so long bursts stay distinguishable
  function automatic ow_cnt_t next_count(ow_cnt_t cur, ow_cnt_t cap);
    return (cur >= cap) ? cap : cur + ow_cnt_t'(1);
  endfunction

  // a closing burst is good only when it carried exactly the word length
  function automatic logic burst_complete(ow_cnt_t cur, ow_cnt_t total);
    return cur == total;
  endfunction

endpackage

// File: rtl/ow_ctrl.sv
module ow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic fp,
  output logic active,
  output logic ev_start,
  output logic ev_cont,
  output logic ev_end
);

  assign ev_start = vld & fp;
  assign ev_cont  = active & vld & ~fp;
  assign ev_end   = active & ~vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active <= 1'b0;
    else if (ev_start) active <= 1'b1;
    else if (ev_end)   active <= 1'b0;
  end

endmodule

// File: rtl/ow_bit_counter.sv
module ow_bit_counter
  import orderwire_pkg::*;
#(
  parameter int TOTAL_BITS = 24
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_start,
  input  logic    ev_cont,
  output ow_cnt_t cnt
);

  localparam ow_cnt_t CAP = ow_cnt_t'(TOTAL_BITS + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (ev_start) cnt <= ow_cnt_t'(1);
    else if (ev_cont)  cnt <= next_count(cnt, CAP);
  end

endmodule

// File: rtl/ow_shift_acc.sv
module ow_shift_acc #(
  parameter int TOTAL_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  bit_in,
  output logic [TOTAL_BITS-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (shift_en) acc <= {acc[TOTAL_BITS-2:0], bit_in};
  end

endmodule

// File: rtl/ow_out_stage.sv
module ow_out_stage #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int TOTAL_BITS = BYTE_W * NUM_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  flag_err,
  input  logic [TOTAL_BITS-1:0] acc,
  output logic [TOTAL_BITS-1:0] word,
  output logic                  ready,
  output logic                  len_err
);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (load) lane_q <= acc[g*BYTE_W +: BYTE_W];
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      len_err <= 1'b0;
    end else begin
      ready <= load;
      if (flag_err) len_err <= 1'b1;
    end
  end

endmodule

// File: rtl/orderwire_capture.sv
module orderwire_capture
  import orderwire_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int TOTAL_BITS = BYTE_W * NUM_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ow_bit,
  input  logic                  ow_vld,
  input  logic                  ow_fp,
  output logic [TOTAL_BITS-1:0] ow_word,
  output logic                  ow_ready,
  output logic                  ow_len_err
);

  // named internal events, visible to the bound checker
  logic                  active;
  logic                  ev_start;
  logic                  ev_cont;
  logic                  ev_end;
  logic                  ev_restart;
  logic                  ev_good;
  logic                  ev_bad;
  ow_cnt_t               cnt;
  logic [TOTAL_BITS-1:0] acc;

  ow_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (ow_vld),
    .fp      (ow_fp),
    .active  (active),
    .ev_start(ev_start),
    .ev_cont (ev_cont),
    .ev_end  (ev_end)
  );

  ow_bit_counter #(.TOTAL_BITS(TOTAL_BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_start(ev_start),
    .ev_cont (ev_cont),
    .cnt     (cnt)
  );

  ow_shift_acc #(.TOTAL_BITS(TOTAL_BITS)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(ev_start | ev_cont),
    .bit_in  (ow_bit),
    .acc     (acc)
  );

  assign ev_restart = active & ev_start;
  assign ev_good    = ev_end & burst_complete(cnt, ow_cnt_t'(TOTAL_BITS));
  assign ev_bad     = ev_end & ~burst_complete(cnt, ow_cnt_t'(TOTAL_BITS));

  ow_out_stage #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_good),
    .flag_err(ev_bad | ev_restart),
    .acc     (acc),
    .word    (ow_word),
    .ready   (ow_ready),
    .len_err (ow_len_err)
  );

endmodule

// File: rtl/orderwire_capture_chk.sv
module orderwire_capture_chk
  import orderwire_pkg::*;
#(
  parameter int TOTAL_BITS = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ow_vld,
  input logic                  ow_fp,
  input logic [TOTAL_BITS-1:0] ow_word,
  input logic                  ow_ready,
  input logic                  ow_len_err,
  input logic                  active,
  input logic                  ev_good,
  input logic                  ev_bad,
  input ow_cnt_t               cnt,
  input logic [TOTAL_BITS-1:0] acc
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_vld && ow_fp) |=> (active && cnt == ow_cnt_t'(1)));

  p_idle_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && ow_vld && !ow_fp) |=> !active);

  p_good_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |=> (ow_ready && ow_word == $past(acc)));

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_good |=> $stable(ow_word));

  p_bad_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (ow_len_err && !ow_ready));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ow_vld && ow_fp) |=> (ow_len_err && cnt == ow_cnt_t'(1)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ow_len_err |=> ow_len_err);

  p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ow_ready |=> !ow_ready);

endmodule

bind orderwire_capture orderwire_capture_chk #(.TOTAL_BITS(TOTAL_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ow_vld    (ow_vld),
  .ow_fp     (ow_fp),
  .ow_word   (ow_word),
  .ow_ready  (ow_ready),
  .ow_len_err(ow_len_err),
  .active    (active),
  .ev_good   (ev_good),
  .ev_bad    (ev_bad),
  .cnt       (cnt),
  .acc       (acc)
);

// File: tb/orderwire_capture_test.sv
module orderwire_capture_test;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ow_bit = 1'b0;
  logic         ow_vld = 1'b0;
  logic         ow_fp = 1'b0;
  logic [W-1:0] ow_word;
  logic         ow_ready;
  logic         ow_len_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  orderwire_capture uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ow_bit    (ow_bit),
    .ow_vld    (ow_vld),
    .ow_fp     (ow_fp),
    .ow_word   (ow_word),
    .ow_ready  (ow_ready),
    .ow_len_err(ow_len_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ow_vld = 1'b0; ow_fp = 1'b0; ow_bit = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive n bits of pat MSB first; first bit carries the marker if mark is set
  task automatic send_bits(logic [W-1:0] pat, int n, bit mark);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ow_vld = 1'b1;
      ow_fp  = (i == 0) && mark;
      ow_bit = (i < W) ? pat[W-1-i] : i[0];
    end
  endtask

  // drop valid, then check outputs in the cycle after the closing edge
  task automatic close_and_check(string req, bit exp_rdy, logic [W-1:0] exp_word,
                                 bit exp_err);
    @(negedge clk);
    ow_vld = 1'b0; ow_fp = 1'b0; ow_bit = 1'b0;
    @(negedge clk);
    chk(req, {31'd0, ow_ready}, {31'd0, exp_rdy});
    chk(req, {8'd0, ow_word}, {8'd0, exp_word});
    chk(req, {31'd0, ow_len_err}, {31'd0, exp_err});
    @(negedge clk);
    chk({req, "/R10"}, {31'd0, ow_ready}, 32'd0);
  endtask

  function automatic logic [W-1:0] pat_of(int k);
    logic [31:0] h;
    h = (k + 1) * 32'h9E3779B1;
    return h[W+3:4];
  endfunction

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1", {8'd0, ow_word}, 32'd0);
    chk("R1", {31'd0, ow_ready}, 32'd0);
    chk("R1", {31'd0, ow_len_err}, 32'd0);

    // R3: valid without marker from idle is ignored
    send_bits(24'hABCDEF, W, 1'b0);
    close_and_check("R3", 1'b0, 24'h0, 1'b0);

    // R4: walking one through every bit position, MSB first
    for (int j = 0; j < W; j++) begin
      send_bits(24'h1 << j, W, 1'b1);
      close_and_check("R4", 1'b1, 24'h1 << j, 1'b0);
    end

    // R2/R5: assorted patterns, including all zeros and all ones
    send_bits(24'h000000, W, 1'b1);
    close_and_check("R5", 1'b1, 24'h000000, 1'b0);
    send_bits(24'hFFFFFF, W, 1'b1);
    close_and_check("R5", 1'b1, 24'hFFFFFF, 1'b0);
    for (int k = 0; k < 16; k++) begin
      send_bits(pat_of(k), W, 1'b1);
      close_and_check("R2", 1'b1, pat_of(k), 1'b0);
    end

    // R6/R7/R9: every length 1..30 after a good capture, from fresh reset
    for (int n = 1; n <= 30; n++) begin
      do_reset();
      send_bits(pat_of(100 + n), W, 1'b1);
      close_and_check("R5", 1'b1, pat_of(100 + n), 1'b0);
      send_bits(pat_of(200 + n), n, 1'b1);
      if (n == W)
        close_and_check("R5", 1'b1, pat_of(200 + n), 1'b0);
      else if (n < W)
        close_and_check("R6", 1'b0, pat_of(100 + n), 1'b1);
      else
        close_and_check("R7", 1'b0, pat_of(100 + n), 1'b1);
      if (n != W) begin
        // R9: error survives a later good capture
        send_bits(pat_of(300 + n), W, 1'b1);
        close_and_check("R9", 1'b1, pat_of(300 + n), 1'b1);
      end
    end

    // R8: marker inside a burst restarts collection
    for (int d = 1; d <= 23; d += 5) begin
      do_reset();
      send_bits(pat_of(400 + d), d, 1'b1);
      send_bits(pat_of(500 + d), W, 1'b1);
      close_and_check("R8", 1'b1, pat_of(500 + d), 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule